// File: doc/BRIEF.md
# Two-Read One-Write Register Bank

This block stores a set of general-purpose data words for a processor datapath. Two read ports can fetch operands at the same time, and one write port stores a result. Each read port has its own index. Its output is a combinational function of that index and of the stored contents. The word at index zero always reads as zero, so software can use it as a constant source and as a discard target.

Writes commit on the falling clock edge. Operands are read during the second half of the cycle, so a result written in the first half of a cycle is already visible to a read in the same cycle, without any forwarding logic. A synchronous, active-high reset clears the stored words. Reset is sampled on the same falling edge as the writes.

Top module: `regbank_2r1w`

## Requirements
- R1: The bank holds 32 words of 32 bits at indices 0 to 31. After a write to any index from 1 to 31, a read of that index returns the written word until another write or a reset changes it.
- R2: A read at index 0 returns all zeros. A write aimed at index 0 leaves every read unchanged.
- R3: The two read ports are independent. Each port returns the word addressed by its own index, whatever index the other port uses.
- R4: A write takes effect on the falling clock edge. Before that edge a read returns the old word, and after it the read returns the new word, in the same cycle.
- R5: While the write enable is 0, no stored word changes, whatever the write index and data are.
- R6: When reset is 1 at a falling edge, indices 1 to 31 read as zero afterwards. The write presented at that edge is discarded.
- R7: When both read ports use the same index, they return the same value.
- R8: Reads are combinational. A change of a read index changes that port's output without waiting for a clock edge.

Port widths: each index port is 5 bits wide (0 to 31), and each data port is 32 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its falling edge |
| rst | input | 1 | Synchronous active-high clear |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Index of the word to write |
| wr_val | input | 32 | Data to write |
| rd_a_idx | input | 5 | Index for read port A |
| rd_a_val | output | 32 | Word read by port A |
| rd_b_idx | input | 5 | Index for read port B |
| rd_b_val | output | 32 | Word read by port B |

## Verification
A corrupted or stale stored word shows up on a read port as soon as an index selects it. The bench compares both read ports against a behavioural model twice in every cycle: once before the falling edge and once after it. A write on the wrong edge, a dropped write or a write that lands at the wrong index is therefore seen within half a cycle of the moment the word is read. Sweeping both ports over every index after the fill exposes a stray write to an index that was not addressed.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DEF_ENTRIES = 32;
  localparam int DEF_WIDTH   = 32;
  localparam int NUM_RD      = 2;
endpackage

// File: rtl/regbank_store.sv
module regbank_store #(
  parameter int ENTRIES = 32,
  parameter int WIDTH   = 32,
  parameter int IDXW    = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [IDXW-1:0]                 wr_idx,
  input  logic [WIDTH-1:0]                wr_val,
  output logic [ENTRIES-1:0][WIDTH-1:0]   words
);
  // Falling-edge commit: the second half-cycle sees the new word.
  always_ff @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) words[i] <= '0;
    end else if (wr_en && (wr_idx != '0)) begin
      words[wr_idx] <= wr_val;
    end
  end
endmodule

// File: rtl/regbank_rdport.sv
module regbank_rdport #(
  parameter int ENTRIES = 32,
  parameter int WIDTH   = 32,
  parameter int IDXW    = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][WIDTH-1:0] words,
  input  logic [IDXW-1:0]               idx,
  output logic [WIDTH-1:0]              val
);
  // Index zero is forced to zero, whatever the stored entry holds.
  always_comb begin
    if (idx == '0) val = '0;
    else           val = words[idx];
  end
endmodule

// File: rtl/regbank_2r1w.sv
module regbank_2r1w #(
  parameter int ENTRIES = regbank_pkg::DEF_ENTRIES,
  parameter int WIDTH   = regbank_pkg::DEF_WIDTH,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [WIDTH-1:0] wr_val,
  input  logic [IDXW-1:0]  rd_a_idx,
  output logic [WIDTH-1:0] rd_a_val,
  input  logic [IDXW-1:0]  rd_b_idx,
  output logic [WIDTH-1:0] rd_b_val
);
  localparam int NRD = regbank_pkg::NUM_RD;

  logic [ENTRIES-1:0][WIDTH-1:0] words;
  logic [NRD-1:0][IDXW-1:0]      rd_idx;
  logic [NRD-1:0][WIDTH-1:0]     rd_val;

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;
  assign rd_a_val  = rd_val[0];
  assign rd_b_val  = rd_val[1];

  regbank_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .IDXW(IDXW)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_val (wr_val),
    .words  (words)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    regbank_rdport #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .IDXW(IDXW)) u_rd (
      .words (words),
      .idx   (rd_idx[p]),
      .val   (rd_val[p])
    );
  end
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int WIDTH = 32,
  parameter int IDXW  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [IDXW-1:0]  wr_idx,
  input logic [WIDTH-1:0] wr_val,
  input logic [IDXW-1:0]  rd_a_idx,
  input logic [WIDTH-1:0] rd_a_val,
  input logic [IDXW-1:0]  rd_b_idx,
  input logic [WIDTH-1:0] rd_b_val
);
  // R2: index zero reads zero
  a_r2_zero_a: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == '0) |-> (rd_a_val == '0));
  a_r2_zero_b: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == '0) |-> (rd_b_val == '0));

  // R7: same index, same value
  a_r7_same_idx: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == rd_b_idx) |-> (rd_a_val == rd_b_val));

  // R1 / R4: a committed write is visible at the next falling edge
  a_r4_write_seen: assert property (@(negedge clk) disable iff (rst)
    (wr_en && (wr_idx != '0) && (wr_idx == rd_a_idx)) |=>
    ((rd_a_idx != $past(rd_a_idx)) || (rd_a_val == $past(wr_val))));

  // R5: a word that is not written keeps its value
  a_r5_hold: assert property (@(negedge clk) disable iff (rst)
    (!wr_en || (wr_idx != rd_b_idx)) |=>
    ((rd_b_idx != $past(rd_b_idx)) || $stable(rd_b_val)));

  // R6: reset clears every word
  a_r6_clear: assert property (@(negedge clk)
    rst |=> ((rd_a_val == '0) && (rd_b_val == '0)));
endmodule

bind regbank_2r1w regbank_chk #(.WIDTH(WIDTH), .IDXW(IDXW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .wr_val   (wr_val),
  .rd_a_idx (rd_a_idx),
  .rd_a_val (rd_a_val),
  .rd_b_idx (rd_b_idx),
  .rd_b_val (rd_b_val)
);

// File: tb/regbank_2r1w_test.sv
module regbank_2r1w_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_val = '0;
  logic [4:0]  rd_a_idx = '0;
  logic [4:0]  rd_b_idx = '0;
  logic [31:0] rd_a_val, rd_b_val;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [32];

  always #10 clk = ~clk;

  regbank_2r1w uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .rd_a_idx(rd_a_idx), .rd_a_val(rd_a_val),
    .rd_b_idx(rd_b_idx), .rd_b_val(rd_b_val)
  );

  function automatic logic [31:0] expect_rd(input logic [4:0] i);
    return (i == 5'd0) ? 32'd0 : model[i];
  endfunction

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp,
                     input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_ports(input string tag);
    cmp(rd_a_val, expect_rd(rd_a_idx), tag);
    cmp(rd_b_val, expect_rd(rd_b_idx), tag);
  endtask

  // One clock: drive after the rising edge, check the first half,
  // update the model at the falling edge, check the second half.
  task automatic cycle(input logic r, input logic we, input logic [4:0] wi,
                       input logic [31:0] wv, input logic [4:0] a,
                       input logic [4:0] b, input string tag);
    @(posedge clk);
    #2;
    rst = r; wr_en = we; wr_idx = wi; wr_val = wv;
    rd_a_idx = a; rd_b_idx = b;
    #3;
    if (!$isunknown(rd_a_val)) check_ports({tag, " first-half R4"});
    @(negedge clk);
    if (r) begin
      for (int i = 0; i < 32; i++) model[i] = '0;
    end else if (we && wi != 5'd0) begin
      model[wi] = wv;
    end
    #5;
    check_ports(tag);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    // R6: reset state
    cycle(1'b1, 1'b1, 5'd3, 32'hDEAD_BEEF, 5'd3, 5'd0, "R6 reset");
    cycle(1'b1, 1'b0, 5'd0, 32'h0, 5'd3, 5'd31, "R6 reset");
    // R1 R4: fill, reading the word being written on port A
    for (int i = 1; i < 32; i++)
      cycle(1'b0, 1'b1, 5'(i), (32'(i) * 32'h0101_0101) ^ 32'hA500_0000,
            5'(i), 5'(i - 1), "R1 fill");
    // R2: write to index 0 ignored
    cycle(1'b0, 1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd1, "R2 zero write");
    cycle(1'b0, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "R2 zero read");
    // R3: independent sweeps
    for (int i = 0; i < 32; i++)
      cycle(1'b0, 1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i), "R3 sweep");
    // R5: disabled write to index 5
    cycle(1'b0, 1'b0, 5'd5, 32'h1234_5678, 5'd5, 5'd6, "R5 no enable");
    cycle(1'b0, 1'b0, 5'd5, 32'h1234_5678, 5'd5, 5'd5, "R5 hold");
    // R7: both ports on one index, with a write to it
    cycle(1'b0, 1'b1, 5'd9, 32'h0BAD_F00D, 5'd9, 5'd9, "R7 same index");
    cycle(1'b0, 1'b1, 5'd31, 32'h8000_0001, 5'd31, 5'd31, "R7 same index");
    // R8: combinational index change mid-cycle
    @(posedge clk);
    #2;
    wr_en = 1'b0;
    rd_a_idx = 5'd7; rd_b_idx = 5'd9;
    #1 check_ports("R8 comb read");
    rd_a_idx = 5'd9; rd_b_idx = 5'd0;
    #1 check_ports("R8 comb read");
    rd_a_idx = 5'd31;
    #1 check_ports("R8 comb read");
    // R6: mid-run reset then a write afterwards
    cycle(1'b1, 1'b1, 5'd12, 32'h5555_AAAA, 5'd12, 5'd31, "R6 mid reset");
    cycle(1'b0, 1'b0, 5'd0, 32'h0, 5'd9, 5'd1, "R6 cleared");
    cycle(1'b0, 1'b1, 5'd12, 32'h7777_0000, 5'd12, 5'd12, "R1 after reset");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule